// File: doc/BRIEF.md
# Pin-Level Fault Forcing Controller

This block drives the control lines of external fault actuators so that a chosen set of target pins can be forced into a faulty condition for a bounded window, or indefinitely. The host writes a staged parameter set through a small register port. This set holds a per-probe fault type, a probe participation mask, an address and a data trigger pattern, each with a compare mask, and a window length with its unit. None of it reaches the actuators until an arm command copies the whole staged set into the live bank at once.

Once armed, the block watches the processor address or data bus on every strobe of the CPU-cycle input. On the first matching strobe it snapshots the live pin values and turns on every selected probe in the same clock edge. Depending on the probe's type, the probe then drives a constant, drives the complement of its snapshot, opens the line, or bridges the probe to its pair partner. The window is counted in CPU-cycle strobes or in prescaled clock ticks. A length of zero makes the fault permanent until the host sends a release command.

Top module: `pff_ctrl`

## Requirements
- R1: After reset, and whenever no fault is active, `drv_en`, `drv_val`, `disc`, `bridge` and `fault_active` are all zero.
- R2: Writes to register indexes 0 to 6 only change a staged copy. Outputs and the active parameters change only through a write of 1 in bit 0 to index 7 (arm). The arm command copies the staged set and puts the block into the waiting state.
- R3: While waiting, the fault fires on the clock edge where `cyc_stb` is high and the selected bus matches. A bus matches when it equals the programmed value on every bit whose mask bit is 1. Index 2 holds the address value and index 3 the address mask. Index 4 holds the data value and index 5 the data mask. Control (index 6) bit 17 chooses the data bus (1) or the address bus (0). A matching bus without `cyc_stb` does not fire.
- R4: The fault type of probe i sits in bits [3i+2:3i] of index 0. Code 001 (stuck-at-0) gives enable 1 and value 0. Code 010 (stuck-at-1) gives enable 1 and value 1. Code 000 does nothing.
- R5: Code 011 (invert) gives enable 1 and drives the complement of the pin value sampled at the firing edge. Later pin changes do not alter the driven value.
- R6: Code 100 (open) sets `disc[i]` with no drive enable. Code 101 (short) sets `bridge[i/2]`, which is shared by probes 2k and 2k+1, with no drive enable.
- R7: Only probes whose bit is 1 in index 1 (the selection mask) show any effect. The other probes stay quiet whatever their type.
- R8: With control bit 16 = 0 and length N (bits [15:0]) nonzero, the fault stays active for exactly N `cyc_stb` strobes after the firing edge.
- R9: With control bit 16 = 1 and length N nonzero, the fault stays active for exactly N × TICK_DIV clock cycles.
- R10: A length of 0 keeps the fault active with no time limit.
- R11: A write of 1 in bit 1 to index 7 (release) returns the block to idle on that edge. Release takes priority over a trigger match in the same cycle and over an arm bit in the same write.
- R12: All probe outputs take their new values on the same clock edge, both when the fault fires and when it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index |
| cfg_wdata | input | 32 | Register write data |
| bus_addr | input | AW | Monitored processor address bus |
| bus_data | input | DW | Monitored processor data bus |
| cyc_stb | input | 1 | One pulse per processor bus cycle |
| pin_in | input | NPROBE | Live values of the target pins |
| drv_val | output | NPROBE | Value each actuator forces |
| drv_en | output | NPROBE | Per-probe drive enable |
| disc | output | NPROBE | Per-probe line disconnect |
| bridge | output | (NPROBE+1)/2 | Per-pair bridge control |
| fault_active | output | 1 | High while the fault window is open |

## Verification
Two events can land in one cycle: a matching bus strobe and a host release command. The bench also drives arm and release in a single command write. It raises `cyc_stb` with a matching address in the same cycle as the release write. It then expects `fault_active` and every probe output to stay low, and a later matching strobe must still fire nothing, because the block has gone back to idle. The combined arm-plus-release write is judged the same way: release wins, so no later trigger takes effect.

// File: rtl/pff_pkg.sv
package pff_pkg;

   typedef enum logic [2:0] {
      FT_NONE  = 3'd0,
      FT_SA0   = 3'd1,
      FT_SA1   = 3'd2,
      FT_INV   = 3'd3,
      FT_OPEN  = 3'd4,
      FT_SHORT = 3'd5
   } fault_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ARMED,
      ST_ACTIVE
   } win_state_e;

   localparam logic [2:0] IX_TYPES = 3'd0;
   localparam logic [2:0] IX_SEL   = 3'd1;
   localparam logic [2:0] IX_AVAL  = 3'd2;
   localparam logic [2:0] IX_AMSK  = 3'd3;
   localparam logic [2:0] IX_DVAL  = 3'd4;
   localparam logic [2:0] IX_DMSK  = 3'd5;
   localparam logic [2:0] IX_CTRL  = 3'd6;
   localparam logic [2:0] IX_CMD   = 3'd7;

   localparam int CTRL_UNIT_BIT = 16;
   localparam int CTRL_BUS_BIT  = 17;

endpackage

// File: rtl/pff_cfg.sv
module pff_cfg
   import pff_pkg::*;
#(
   parameter int NPROBE = 8,
   parameter int AW     = 32,
   parameter int DW     = 32,
   parameter int DURW   = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [2:0]          cfg_addr,
   input  logic [31:0]         cfg_wdata,
   output logic [3*NPROBE-1:0] lv_types,
   output logic [NPROBE-1:0]   lv_sel,
   output logic [AW-1:0]       lv_aval,
   output logic [AW-1:0]       lv_amsk,
   output logic [DW-1:0]       lv_dval,
   output logic [DW-1:0]       lv_dmsk,
   output logic [DURW-1:0]     lv_len,
   output logic                lv_unit,
   output logic                lv_bus,
   output logic                arm_p,
   output logic                rel_p
);
   localparam int TYW = 3 * NPROBE;

   logic [TYW-1:0]    sh_types;
   logic [NPROBE-1:0] sh_sel;
   logic [AW-1:0]     sh_aval, sh_amsk;
   logic [DW-1:0]     sh_dval, sh_dmsk;
   logic [DURW-1:0]   sh_len;
   logic              sh_unit, sh_bus;

   logic cmd_wr;
   assign cmd_wr = cfg_we && (cfg_addr == IX_CMD);
   assign rel_p  = cmd_wr && cfg_wdata[1];
   assign arm_p  = cmd_wr && cfg_wdata[0] && !cfg_wdata[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_types <= '0;
         sh_sel   <= '0;
         sh_aval  <= '0;
         sh_amsk  <= '0;
         sh_dval  <= '0;
         sh_dmsk  <= '0;
         sh_len   <= '0;
         sh_unit  <= 1'b0;
         sh_bus   <= 1'b0;
      end else if (cfg_we) begin
         case (cfg_addr)
            IX_TYPES: sh_types <= cfg_wdata[TYW-1:0];
            IX_SEL:   sh_sel   <= cfg_wdata[NPROBE-1:0];
            IX_AVAL:  sh_aval  <= cfg_wdata[AW-1:0];
            IX_AMSK:  sh_amsk  <= cfg_wdata[AW-1:0];
            IX_DVAL:  sh_dval  <= cfg_wdata[DW-1:0];
            IX_DMSK:  sh_dmsk  <= cfg_wdata[DW-1:0];
            IX_CTRL: begin
               sh_len  <= cfg_wdata[DURW-1:0];
               sh_unit <= cfg_wdata[CTRL_UNIT_BIT];
               sh_bus  <= cfg_wdata[CTRL_BUS_BIT];
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lv_types <= '0;
         lv_sel   <= '0;
         lv_aval  <= '0;
         lv_amsk  <= '0;
         lv_dval  <= '0;
         lv_dmsk  <= '0;
         lv_len   <= '0;
         lv_unit  <= 1'b0;
         lv_bus   <= 1'b0;
      end else if (arm_p) begin
         lv_types <= sh_types;
         lv_sel   <= sh_sel;
         lv_aval  <= sh_aval;
         lv_amsk  <= sh_amsk;
         lv_dval  <= sh_dval;
         lv_dmsk  <= sh_dmsk;
         lv_len   <= sh_len;
         lv_unit  <= sh_unit;
         lv_bus   <= sh_bus;
      end
   end

   // R2: the live bank moves only on an arm command
   a_r2_live_held: assert property (@(posedge clk) disable iff (!rst_n)
      !arm_p |=> ($stable(lv_types) && $stable(lv_sel) && $stable(lv_len)));

endmodule

// File: rtl/pff_trig.sv
module pff_trig #(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_data,
   input  logic [AW-1:0] aval,
   input  logic [AW-1:0] amsk,
   input  logic [DW-1:0] dval,
   input  logic [DW-1:0] dmsk,
   input  logic          use_data,
   output logic          hit
);
   logic a_hit, d_hit;

   assign a_hit = ((bus_addr ^ aval) & amsk) == '0;
   assign d_hit = ((bus_data ^ dval) & dmsk) == '0;
   assign hit   = use_data ? d_hit : a_hit;

endmodule

// File: rtl/pff_window.sv
module pff_window
   import pff_pkg::*;
#(
   parameter int DURW     = 16,
   parameter int TICK_DIV = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            arm_p,
   input  logic            rel_p,
   input  logic            hit,
   input  logic            cyc_stb,
   input  logic [DURW-1:0] len,
   input  logic            unit_time,
   output logic            active,
   output logic            fire
);
   localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
   localparam logic [TW-1:0] TLAST = TW'(TICK_DIV - 1);

   win_state_e      state;
   logic [DURW-1:0] remain;
   logic [TW-1:0]   tick_cnt;
   logic            tick, evt;

   assign tick   = (tick_cnt == TLAST);
   assign evt    = unit_time ? tick : cyc_stb;
   assign fire   = (state == ST_ARMED) && cyc_stb && hit && !rel_p && !arm_p;
   assign active = (state == ST_ACTIVE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         remain   <= '0;
         tick_cnt <= '0;
      end else if (rel_p) begin
         state <= ST_IDLE;
      end else if (arm_p) begin
         state <= ST_ARMED;
      end else begin
         case (state)
            ST_ARMED: if (fire) begin
               state    <= ST_ACTIVE;
               remain   <= len;
               tick_cnt <= '0;
            end
            ST_ACTIVE: begin
               tick_cnt <= tick ? '0 : tick_cnt + 1'b1;
               if (remain != '0 && evt) begin
                  if (remain == DURW'(1)) state <= ST_IDLE;
                  remain <= remain - 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   // R11: a release leaves the block idle on the next cycle
   a_r11_release_idles: assert property (@(posedge clk) disable iff (!rst_n)
      rel_p |=> (state == ST_IDLE));

   // R10: a zero-length window never ends by itself
   a_r10_permanent_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (active && remain == '0 && !rel_p && !arm_p) |=> active);

   // R3: entry into the window needs a strobe and a bus match
   a_r3_entry_on_match: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !$past(active)) |-> ($past(cyc_stb) && $past(hit)));

   // R8: last counted strobe closes a cycle-counted window
   a_r8_last_strobe_closes: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !unit_time && remain == DURW'(1) && cyc_stb && !rel_p && !arm_p)
      |=> !active);

endmodule

// File: rtl/pff_drive.sv
module pff_drive
   import pff_pkg::*;
#(
   parameter int NPROBE = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                active,
   input  logic                fire,
   input  logic [3*NPROBE-1:0] types,
   input  logic [NPROBE-1:0]   sel,
   input  logic [NPROBE-1:0]   pin_in,
   output logic [NPROBE-1:0]   drv_val,
   output logic [NPROBE-1:0]   drv_en,
   output logic [NPROBE-1:0]   disc,
   output logic [(NPROBE+1)/2-1:0] bridge
);
   localparam int NPAIR = (NPROBE + 1) / 2;

   logic [NPROBE-1:0] snap;
   logic [NPROBE-1:0] shrt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    snap <= '0;
      else if (fire) snap <= pin_in;
   end

   for (genvar i = 0; i < NPROBE; i++) begin : g_probe
      fault_e ft;
      always_comb begin
         ft         = fault_e'(types[3*i +: 3]);
         drv_en[i]  = 1'b0;
         drv_val[i] = 1'b0;
         disc[i]    = 1'b0;
         shrt[i]    = 1'b0;
         if (active && sel[i]) begin
            case (ft)
               FT_SA0:   drv_en[i] = 1'b1;
               FT_SA1:   begin drv_en[i] = 1'b1; drv_val[i] = 1'b1; end
               FT_INV:   begin drv_en[i] = 1'b1; drv_val[i] = ~snap[i]; end
               FT_OPEN:  disc[i] = 1'b1;
               FT_SHORT: shrt[i] = 1'b1;
               default:  ;
            endcase
         end
      end
   end

   for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      if (2*p + 1 < NPROBE) begin : g_full
         assign bridge[p] = shrt[2*p] | shrt[2*p+1];
      end else begin : g_half
         assign bridge[p] = shrt[2*p];
      end
   end

   // R1: nothing reaches the actuators outside a window
   a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> (drv_en == '0 && disc == '0 && bridge == '0));

   // R5: the invert snapshot is frozen while the window is open
   a_r5_snapshot_held: assert property (@(posedge clk) disable iff (!rst_n)
      (active && $past(active)) |-> $stable(snap));

endmodule

// File: rtl/pff_ctrl.sv
module pff_ctrl
   import pff_pkg::*;
#(
   parameter int NPROBE   = 8,
   parameter int AW       = 32,
   parameter int DW       = 32,
   parameter int DURW     = 16,
   parameter int TICK_DIV = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cfg_we,
   input  logic [2:0]                cfg_addr,
   input  logic [31:0]               cfg_wdata,
   input  logic [AW-1:0]             bus_addr,
   input  logic [DW-1:0]             bus_data,
   input  logic                      cyc_stb,
   input  logic [NPROBE-1:0]         pin_in,
   output logic [NPROBE-1:0]         drv_val,
   output logic [NPROBE-1:0]         drv_en,
   output logic [NPROBE-1:0]         disc,
   output logic [(NPROBE+1)/2-1:0]   bridge,
   output logic                      fault_active
);
   if (NPROBE < 2 || 3*NPROBE > 32) begin : g_bad_nprobe
      $error("pff_ctrl: NPROBE must lie in 2..10");
   end
   if (AW < 1 || AW > 32 || DW < 1 || DW > 32) begin : g_bad_bus
      $error("pff_ctrl: bus widths must lie in 1..32");
   end
   if (DURW < 1 || DURW > CTRL_UNIT_BIT) begin : g_bad_len
      $error("pff_ctrl: DURW must lie in 1..16");
   end
   if (TICK_DIV < 1) begin : g_bad_tick
      $error("pff_ctrl: TICK_DIV must be at least 1");
   end

   logic [3*NPROBE-1:0] lv_types;
   logic [NPROBE-1:0]   lv_sel;
   logic [AW-1:0]       lv_aval, lv_amsk;
   logic [DW-1:0]       lv_dval, lv_dmsk;
   logic [DURW-1:0]     lv_len;
   logic                lv_unit, lv_bus, arm_p, rel_p, hit, fire, active;

   pff_cfg #(.NPROBE(NPROBE), .AW(AW), .DW(DW), .DURW(DURW)) u_cfg (
      .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata,
      .lv_types, .lv_sel, .lv_aval, .lv_amsk, .lv_dval, .lv_dmsk,
      .lv_len, .lv_unit, .lv_bus, .arm_p, .rel_p
   );

   pff_trig #(.AW(AW), .DW(DW)) u_trig (
      .bus_addr, .bus_data, .aval(lv_aval), .amsk(lv_amsk),
      .dval(lv_dval), .dmsk(lv_dmsk), .use_data(lv_bus), .hit
   );

   pff_window #(.DURW(DURW), .TICK_DIV(TICK_DIV)) u_win (
      .clk, .rst_n, .arm_p, .rel_p, .hit, .cyc_stb,
      .len(lv_len), .unit_time(lv_unit), .active, .fire
   );

   pff_drive #(.NPROBE(NPROBE)) u_drv (
      .clk, .rst_n, .active, .fire, .types(lv_types), .sel(lv_sel),
      .pin_in, .drv_val, .drv_en, .disc, .bridge
   );

   assign fault_active = active;

endmodule

// File: tb/pff_ctrl_bench.sv
module pff_ctrl_bench;
   localparam int NP = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] bus_addr = '0;
   logic [31:0] bus_data = '0;
   logic        cyc_stb = 1'b0;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] drv_val, drv_en, disc;
   logic [3:0]  bridge;
   logic        fault_active;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   pff_ctrl u_pff_ctrl (
      .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .bus_addr, .bus_data,
      .cyc_stb, .pin_in, .drv_val, .drv_en, .disc, .bridge, .fault_active
   );

   // {types 24, sel 8, pins 8, exp en 8, exp val 8, exp disc 8, exp bridge 4}
   localparam int NV = 6;
   localparam logic [67:0] VEC [NV] = '{
      {24'h492492, 8'hFF, 8'h00, 8'hFF, 8'hFF, 8'h00, 4'h0},
      {24'h249249, 8'h0F, 8'h00, 8'h0F, 8'h00, 8'h00, 4'h0},
      {24'h6DB6DB, 8'hFF, 8'hA5, 8'hFF, 8'h5A, 8'h00, 4'h0},
      {24'h924924, 8'hC3, 8'h00, 8'h00, 8'h00, 8'hC3, 4'h0},
      {24'hB6DB6D, 8'h21, 8'h00, 8'h00, 8'h00, 8'h00, 4'h5},
      {24'hA858D1, 8'h7F, 8'h04, 8'h47, 8'h42, 8'h08, 4'h4}
   };

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [2:0] a, logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic strobe(logic [31:0] a, logic [31:0] d);
      @(negedge clk);
      cyc_stb = 1'b1; bus_addr = a; bus_data = d;
      @(negedge clk);
      cyc_stb = 1'b0; bus_addr = '0; bus_data = '0;
   endtask

   task automatic setup(logic [23:0] ty, logic [7:0] sel, logic [31:0] ctrl);
      wr(3'd0, {8'h00, ty});
      wr(3'd1, {24'h0, sel});
      wr(3'd2, 32'h0000_1000);
      wr(3'd3, 32'hFFFF_FFFF);
      wr(3'd4, 32'hCAFE_0000);
      wr(3'd5, 32'hFFFF_0000);
      wr(3'd6, ctrl);
   endtask

   function automatic logic [31:0] outs();
      return {drv_en, drv_val, disc, 3'b000, fault_active, bridge};
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      chk("R1 reset outputs", outs(), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after reset", outs(), 32'h0);

      // table walk: permanent windows, address trigger
      for (int v = 0; v < NV; v++) begin
         setup(VEC[v][67:44], VEC[v][43:36], 32'h0);
         pin_in = VEC[v][35:28];
         wr(3'd7, 32'h1);
         chk("R12 quiet before fire", outs(), 32'h0);
         strobe(32'h0000_1000, 32'h0);
         chk("R4 R6 R7 drive enables", {24'h0, drv_en}, {24'h0, VEC[v][27:20]});
         chk("R4 R5 drive values", {24'h0, drv_val}, {24'h0, VEC[v][19:12]});
         chk("R6 disconnect", {24'h0, disc}, {24'h0, VEC[v][11:4]});
         chk("R6 bridge", {28'h0, bridge}, {28'h0, VEC[v][3:0]});
         wr(3'd7, 32'h2);
         chk("R12 all released", outs(), 32'h0);
      end

      // R5: snapshot frozen after fire
      setup(24'h6DB6DB, 8'hFF, 32'h0);
      pin_in = 8'h3C;
      wr(3'd7, 32'h1);
      strobe(32'h0000_1000, 32'h0);
      pin_in = 8'hFF;
      repeat (3) @(negedge clk);
      chk("R5 invert uses snapshot", {24'h0, drv_val}, 32'h0000_00C3);

      // R2: staged writes do not reach an open window
      wr(3'd0, 32'h0024_9249);
      wr(3'd1, 32'h0000_0001);
      chk("R2 staged types ignored", {24'h0, drv_val}, 32'h0000_00C3);
      chk("R2 staged select ignored", {24'h0, drv_en}, 32'h0000_00FF);
      wr(3'd7, 32'h2);
      // R2: staged set without arm does not fire
      setup(24'h492492, 8'hFF, 32'h0);
      strobe(32'h0000_1000, 32'h0);
      chk("R2 no arm no fire", outs(), 32'h0);

      // R3: data-bus trigger with mask
      setup(24'h492492, 8'hFF, 32'h0002_0000);
      wr(3'd7, 32'h1);
      strobe(32'h0000_1000, 32'h1234_0000);
      chk("R3 data mismatch", {31'h0, fault_active}, 32'h0);
      @(negedge clk);
      bus_data = 32'hCAFE_5555;
      @(negedge clk);
      bus_data = '0;
      chk("R3 match without strobe", {31'h0, fault_active}, 32'h0);
      strobe(32'h0, 32'hCAFE_1234);
      chk("R3 data match fires", {31'h0, fault_active}, 32'h1);
      wr(3'd7, 32'h2);

      // R8: three strobes
      setup(24'h492492, 8'hFF, 32'h0000_0003);
      wr(3'd7, 32'h1);
      @(negedge clk);
      cyc_stb = 1'b1; bus_addr = 32'h0000_1000;
      @(negedge clk);
      bus_addr = 32'h0;
      n = 0;
      for (int k = 0; k < 10; k++) begin
         if (fault_active) n++;
         @(negedge clk);
      end
      cyc_stb = 1'b0;
      chk("R8 cycle window length", n, 3);

      // R9: two ticks of four clocks
      setup(24'h492492, 8'hFF, 32'h0001_0002);
      wr(3'd7, 32'h1);
      strobe(32'h0000_1000, 32'h0);
      n = 0;
      for (int k = 0; k < 20; k++) begin
         if (fault_active) n++;
         @(negedge clk);
      end
      chk("R9 time window length", n, 8);

      // R10: permanent window under many strobes
      setup(24'h492492, 8'hFF, 32'h0);
      wr(3'd7, 32'h1);
      strobe(32'h0000_1000, 32'h0);
      cyc_stb = 1'b1;
      repeat (40) @(negedge clk);
      cyc_stb = 1'b0;
      chk("R10 permanent still active", {31'h0, fault_active}, 32'h1);
      wr(3'd7, 32'h2);
      chk("R11 release ends window", outs(), 32'h0);

      // R11: release and matching strobe in the same cycle
      wr(3'd7, 32'h1);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 3'd7; cfg_wdata = 32'h2;
      cyc_stb = 1'b1; bus_addr = 32'h0000_1000;
      @(negedge clk);
      cfg_we = 1'b0; cyc_stb = 1'b0; bus_addr = '0;
      chk("R11 release beats trigger", outs(), 32'h0);
      strobe(32'h0000_1000, 32'h0);
      chk("R11 idle after release", outs(), 32'h0);
      // R11: arm and release in one write
      wr(3'd7, 32'h3);
      strobe(32'h0000_1000, 32'h0);
      chk("R11 release beats arm", outs(), 32'h0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule